// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

A synchronous up-counter whose width is set by a parameter, four bits by default. Every state bit is captured on the same rising clock edge, so all outputs move at one instant. At each edge the counter either clears, takes a parallel preset word, steps up by one or holds. Which of these happens depends on an active-low clear, an active-low load and two count-enable inputs called P and T.

The carry output goes high when the count sits at its top value and T is high. P has no part in the carry. Tying one stage's carry to the next stage's T, with P shared across all stages, gives a wider synchronous counter that needs no glue logic. A parameter sets the clear either to act on the clock edge or to force zero at once. With the edge-timed clear, an outside decode of a chosen terminal count can feed the clear input, which shortens the count cycle.

Top module: `casc_bin_counter`

## Requirements
- R1: With clear and load both high and P and T both high, the count rises by exactly one on each rising edge.
- R2: With clear and load both high and either P or T low, the count keeps its value across the edge.
- R3: The carry output is high exactly when the count is all ones and T is high. P has no effect on the carry.
- R4: A low load at a rising edge copies the data input into the count, whatever the enable levels.
- R5: In edge-timed clear mode (the default), a low clear makes the count zero at the next rising edge. This wins over load and both enables.
- R6: In immediate clear mode, a low clear forces the count to zero with no clock edge needed, and holds it there while clear stays low.
- R7: An enabled count at the all-ones value becomes zero on the next edge.
- R8: Changes on P, T, load or data between edges leave the count unchanged until the next rising edge.
- R9: Several stages chained carry-to-T with P shared count as one wide counter. This includes the passes across stage boundaries and the wrap of the full chain.
- R10: In edge-timed clear mode, feeding clear from a decode of count value N gives a repeating cycle of N+1 states, from 0 up to N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all state bits |
| clr_n | input | 1 | Active-low clear; timing set by CLR_MODE |
| load_n | input | 1 | Active-low synchronous parallel preset |
| en_p | input | 1 | Count enable P; gates counting only |
| en_t | input | 1 | Count enable T; gates counting and the carry |
| din | input | WIDTH | Preset data |
| q | output | WIDTH | Current count |
| rco | output | 1 | Carry: count all ones and T high |

## Verification
A free run of more than one full period separates a correct increment and wrap from a count that sticks or skips at the top value. Holds with only P low and with only T low show that each enable gates counting on its own. A held top value shows the carry following T and ignoring P. Loads and clears applied together with active enables, and with each other, confirm the priority order. A mid-cycle pulse on the immediate-clear variant, a three-stage chain run through both a stage boundary and the full wrap, and a decade loop built from a decode on the clear input cover the mode choice, the cascading and the shortened count.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

   // Clear timing variant selected at elaboration
   typedef enum logic {
      CLR_SYNC  = 1'b0,
      CLR_ASYNC = 1'b1
   } clr_mode_e;

   // Edge action when clear is inactive
   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_COUNT = 2'd1,
      OP_LOAD  = 2'd2
   } cnt_op_e;

endpackage

// File: rtl/cbc_op_decode.sv
module cbc_op_decode
   import cbc_pkg::*;
(
   input  logic    load_n,
   input  logic    en_p,
   input  logic    en_t,
   output cnt_op_e op
);

   // Load outranks counting; both enables must be high to count
   always_comb begin
      if (!load_n)
         op = OP_LOAD;
      else if (en_p && en_t)
         op = OP_COUNT;
      else
         op = OP_HOLD;
   end

endmodule

// File: rtl/cbc_next.sv
module cbc_next
   import cbc_pkg::*;
#(
   parameter int W = 4
) (
   input  cnt_op_e        op,
   input  logic [W-1:0]   cur,
   input  logic [W-1:0]   din,
   output logic [W-1:0]   nxt
);

   localparam logic [W-1:0] ONE = W'(1);

   always_comb begin
      unique case (op)
         OP_LOAD:  nxt = din;
         OP_COUNT: nxt = cur + ONE;
         default:  nxt = cur;
      endcase
   end

endmodule

// File: rtl/cbc_state_reg.sv
module cbc_state_reg
   import cbc_pkg::*;
#(
   parameter int        W        = 4,
   parameter clr_mode_e CLR_MODE = CLR_SYNC
) (
   input  logic          clk,
   input  logic          clr_n,
   input  logic [W-1:0]  nxt,
   output logic [W-1:0]  q
);

   localparam logic [W-1:0] ZERO = '0;

   if (CLR_MODE == CLR_ASYNC) begin : g_async_clr
      always_ff @(posedge clk or negedge clr_n) begin
         if (!clr_n)
            q <= ZERO;
         else
            q <= nxt;
      end
   end else begin : g_sync_clr
      always_ff @(posedge clk) begin
         if (!clr_n)
            q <= ZERO;
         else
            q <= nxt;
      end
   end

endmodule

// File: rtl/cbc_carry.sv
module cbc_carry #(
   parameter int W = 4
) (
   input  logic [W-1:0] q,
   input  logic         en_t,
   output logic         rco
);

   // Prefix AND across the state bits; the last stage marks all ones
   logic [W:0] run_ones;
   assign run_ones[0] = 1'b1;

   for (genvar i = 0; i < W; i++) begin : g_prefix
      assign run_ones[i+1] = run_ones[i] & q[i];
   end

   assign rco = run_ones[W] & en_t;

endmodule

// File: rtl/casc_bin_counter.sv
module casc_bin_counter
   import cbc_pkg::*;
#(
   parameter int        WIDTH    = 4,
   parameter clr_mode_e CLR_MODE = CLR_SYNC
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             load_n,
   input  logic             en_p,
   input  logic             en_t,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] q,
   output logic             rco
);

   if (WIDTH < 1) begin : g_bad_width
      $error("casc_bin_counter: WIDTH must be at least 1");
   end

   cnt_op_e          op;
   logic [WIDTH-1:0] nxt;

   cbc_op_decode u_dec (
      .load_n (load_n),
      .en_p   (en_p),
      .en_t   (en_t),
      .op     (op)
   );

   cbc_next #(.W(WIDTH)) u_next (
      .op  (op),
      .cur (q),
      .din (din),
      .nxt (nxt)
   );

   cbc_state_reg #(.W(WIDTH), .CLR_MODE(CLR_MODE)) u_reg (
      .clk   (clk),
      .clr_n (clr_n),
      .nxt   (nxt),
      .q     (q)
   );

   cbc_carry #(.W(WIDTH)) u_carry (
      .q    (q),
      .en_t (en_t),
      .rco  (rco)
   );

endmodule

module casc_bin_counter_chk
   import cbc_pkg::*;
#(
   parameter int        W        = 4,
   parameter clr_mode_e CLR_MODE = CLR_SYNC
) (
   input logic         clk,
   input logic         clr_n,
   input logic         load_n,
   input logic         en_p,
   input logic         en_t,
   input logic [W-1:0] din,
   input logic [W-1:0] q,
   input logic         rco
);

   localparam logic [W-1:0] TOP = '1;

   // Becomes true once a clear has been seen at an edge
   logic armed = 1'b0;
   always_ff @(posedge clk) begin
      if (!clr_n) armed <= 1'b1;
   end

   p_count_step_r1: assert property (@(posedge clk) disable iff (!armed)
      clr_n && $past(clr_n && load_n && en_p && en_t) |-> q == $past(q) + W'(1));

   p_hold_r2: assert property (@(posedge clk) disable iff (!armed)
      clr_n && $past(clr_n && load_n && !(en_p && en_t)) |-> q == $past(q));

   p_rco_needs_t_r3: assert property (@(posedge clk) disable iff (!armed)
      rco |-> en_t);

   p_rco_at_top_r3: assert property (@(posedge clk) disable iff (!armed)
      rco |-> q == TOP);

   p_rco_present_r3: assert property (@(posedge clk) disable iff (!armed)
      (en_t && q == TOP) |-> rco);

   p_load_r4: assert property (@(posedge clk) disable iff (!armed)
      clr_n && $past(clr_n && !load_n) |-> q == $past(din));

   p_wrap_r7: assert property (@(posedge clk) disable iff (!armed)
      clr_n && $past(clr_n && load_n && en_p && en_t && q == TOP) |-> q == '0);

   if (CLR_MODE == CLR_SYNC) begin : g_sync_chk
      p_sync_clear_r5: assert property (@(posedge clk) disable iff (!armed)
         $past(!clr_n) |-> q == '0);
   end else begin : g_async_chk
      p_async_clear_r6: assert property (@(posedge clk) disable iff (!armed)
         !clr_n |-> q == '0);
   end

endmodule

bind casc_bin_counter casc_bin_counter_chk #(.W(WIDTH), .CLR_MODE(CLR_MODE)) u_chk (
   .clk    (clk),
   .clr_n  (clr_n),
   .load_n (load_n),
   .en_p   (en_p),
   .en_t   (en_t),
   .din    (din),
   .q      (q),
   .rco    (rco)
);

// File: tb/casc_bin_counter_tb_top.sv
module casc_bin_counter_tb_top;
   import cbc_pkg::*;

   localparam time HALF = 4ns;

   logic clk = 1'b0;
   always #HALF clk = ~clk;

   int n_vec  = 0;
   int n_miss = 0;

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_vec++;
      if (act !== exp) begin
         n_miss++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // ---------------- main instance, edge-timed clear ----------------
   logic       clr_n = 1'b0, load_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
   logic [3:0] din = '0;
   logic [3:0] q;
   logic       rco;

   casc_bin_counter dut_i (
      .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
      .din(din), .q(q), .rco(rco)
   );

   // ---------------- immediate-clear instance ----------------
   logic       a_clr_n = 1'b0, a_ld_n = 1'b1;
   logic [3:0] a_d = '0;
   logic [3:0] aq;
   logic       a_rco;

   casc_bin_counter #(.WIDTH(4), .CLR_MODE(CLR_ASYNC)) u_async (
      .clk(clk), .clr_n(a_clr_n), .load_n(a_ld_n), .en_p(1'b1), .en_t(1'b1),
      .din(a_d), .q(aq), .rco(a_rco)
   );

   // ---------------- three-stage chain ----------------
   logic        c_clr_n = 1'b0, c_ld_n = 1'b1, c_p = 1'b0;
   logic [11:0] c_d = '0;
   logic [3:0]  c0q, c1q, c2q;
   logic        c0_rco, c1_rco, c2_rco;

   casc_bin_counter u_c0 (
      .clk(clk), .clr_n(c_clr_n), .load_n(c_ld_n), .en_p(c_p), .en_t(1'b1),
      .din(c_d[3:0]), .q(c0q), .rco(c0_rco));
   casc_bin_counter u_c1 (
      .clk(clk), .clr_n(c_clr_n), .load_n(c_ld_n), .en_p(c_p), .en_t(c0_rco),
      .din(c_d[7:4]), .q(c1q), .rco(c1_rco));
   casc_bin_counter u_c2 (
      .clk(clk), .clr_n(c_clr_n), .load_n(c_ld_n), .en_p(c_p), .en_t(c1_rco),
      .din(c_d[11:8]), .q(c2q), .rco(c2_rco));

   // ---------------- decade loop by decode on clear ----------------
   logic       m_go = 1'b0;
   logic [3:0] mq;
   logic       m_rco;
   logic       m_clr_n;
   assign m_clr_n = m_go & (mq != 4'd9);

   casc_bin_counter u_mod (
      .clk(clk), .clr_n(m_clr_n), .load_n(1'b1), .en_p(1'b1), .en_t(1'b1),
      .din(4'd0), .q(mq), .rco(m_rco));

   // ---------------- scoreboard ----------------
   typedef struct {
      logic [3:0] q;
      logic       rco;
      string      tag;
   } exp_t;

   exp_t       sb[$];
   logic [3:0] m_q = '0;

   task automatic step(input logic c, input logic l, input logic p, input logic t,
                       input logic [3:0] d, input string tag);
      exp_t e;
      @(negedge clk);
      clr_n = c; load_n = l; en_p = p; en_t = t; din = d;
      if (!c)          m_q = 4'd0;
      else if (!l)     m_q = d;
      else if (p && t) m_q = m_q + 4'd1;
      e.q   = m_q;
      e.rco = (m_q == 4'hF) && t;
      e.tag = tag;
      sb.push_back(e);
   endtask

   initial begin : monitor
      exp_t e;
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() != 0) begin
            e = sb.pop_front();
            chk(32'(q), 32'(e.q), e.tag);
            chk(32'(rco), 32'(e.rco), {e.tag, " (carry)"});
         end
      end
   end

   // ---------------- watchdog ----------------
   initial begin : watchdog
      #(HALF * 2 * 100000);
      n_miss++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin : stim
      logic [11:0] c_exp;
      logic [3:0]  m_exp;

      // main instance
      step(1'b0, 1'b1, 1'b1, 1'b1, 4'd0, "R5 reset state from clear");
      step(1'b0, 1'b1, 1'b1, 1'b1, 4'd0, "R5 clear overrides enables");
      for (int i = 0; i < 17; i++)
         step(1'b1, 1'b1, 1'b1, 1'b1, 4'd0, "R1 R7 count and wrap");
      step(1'b1, 1'b1, 1'b0, 1'b1, 4'd0, "R2 hold with P low");
      step(1'b1, 1'b1, 1'b0, 1'b1, 4'd0, "R2 hold with P low");
      step(1'b1, 1'b1, 1'b1, 1'b0, 4'd0, "R2 hold with T low");
      step(1'b1, 1'b1, 1'b1, 1'b0, 4'd0, "R2 hold with T low");
      step(1'b1, 1'b0, 1'b0, 1'b0, 4'hF, "R4 load with enables low");
      step(1'b1, 1'b1, 1'b0, 1'b1, 4'd0, "R3 carry with P low");
      step(1'b1, 1'b1, 1'b1, 1'b0, 4'd0, "R3 carry off with T low");
      step(1'b1, 1'b0, 1'b1, 1'b1, 4'd5, "R4 load beats count");
      step(1'b0, 1'b0, 1'b1, 1'b1, 4'd9, "R5 clear beats load");
      step(1'b1, 1'b1, 1'b1, 1'b1, 4'd0, "R1 count after clear");
      step(1'b1, 1'b1, 1'b0, 1'b0, 4'd0, "R2 hold before mid-cycle test");

      // R8: control changes between edges do nothing
      @(posedge clk);
      #2;
      load_n = 1'b0; din = 4'd3; en_p = 1'b1; en_t = 1'b1;
      #1;
      chk(32'(q), 32'(m_q), "R8 no change from mid-cycle load");
      #1;
      load_n = 1'b1; en_p = 1'b0; en_t = 1'b0;
      #1;
      chk(32'(q), 32'(m_q), "R8 no change from mid-cycle enables");

      step(1'b0, 1'b1, 1'b1, 1'b1, 4'd0, "R5 clear beats count");
      @(posedge clk);
      #2;
      chk(32'(sb.size()), 32'd0, "scoreboard drained");

      // immediate-clear instance
      @(negedge clk);
      a_clr_n = 1'b1; a_ld_n = 1'b0; a_d = 4'd9;
      @(posedge clk); #1;
      chk(32'(aq), 32'd9, "R4 load in immediate-clear mode");
      a_ld_n = 1'b1;
      @(posedge clk); #1;
      chk(32'(aq), 32'd10, "R1 count in immediate-clear mode");
      #1;
      a_clr_n = 1'b0;
      #1;
      chk(32'(aq), 32'd0, "R6 clear acts without an edge");
      @(posedge clk); #1;
      chk(32'(aq), 32'd0, "R6 held at zero while clear low");
      a_clr_n = 1'b1;
      @(posedge clk); #1;
      chk(32'(aq), 32'd1, "R6 counts again after release");

      // three-stage chain
      @(negedge clk);
      c_clr_n = 1'b1; c_ld_n = 1'b0; c_d = 12'hFF0;
      @(posedge clk); #1;
      chk(32'({c2q, c1q, c0q}), 32'h0FF0, "R9 chain preset");
      c_exp = 12'hFF0;
      @(negedge clk);
      c_ld_n = 1'b1; c_p = 1'b1;
      for (int i = 0; i < 24; i++) begin
         @(posedge clk); #1;
         c_exp = c_exp + 12'd1;
         chk(32'({c2q, c1q, c0q}), 32'(c_exp), "R9 chain count through full wrap");
      end
      @(negedge clk);
      c_p = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(posedge clk); #1;
         chk(32'({c2q, c1q, c0q}), 32'(c_exp), "R9 chain hold with shared P low");
      end
      @(negedge clk);
      c_ld_n = 1'b0; c_d = 12'h0F8;
      @(posedge clk); #1;
      c_exp = 12'h0F8;
      @(negedge clk);
      c_ld_n = 1'b1; c_p = 1'b1;
      for (int i = 0; i < 20; i++) begin
         @(posedge clk); #1;
         c_exp = c_exp + 12'd1;
         chk(32'({c2q, c1q, c0q}), 32'(c_exp), "R9 chain carry into upper stage");
      end

      // decade loop
      @(negedge clk);
      chk(32'(mq), 32'd0, "R10 held at zero before start");
      m_go = 1'b1;
      m_exp = 4'd0;
      for (int i = 0; i < 25; i++) begin
         @(posedge clk); #1;
         m_exp = (m_exp == 4'd9) ? 4'd0 : m_exp + 4'd1;
         chk(32'(mq), 32'(m_exp), "R10 decode-shortened cycle");
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
   end

endmodule